// File: doc/BRIEF.md
# Byte/Word Selectable Memory Bus Interface

This block is the bus front end of a parallel non-volatile memory model. It samples a strobe-driven external bus into a system clock domain. The bus has chip enable, output enable and write enable, all active low. It also has a bus-width select, a 20-bit word address and a 16-bit data bus that is split into separate input and output vectors, with tristate enables for each lane group.

In 16-bit mode the block returns whole words from a small internal array. In 8-bit mode the topmost data pin stops carrying data. It becomes the least significant address bit and picks one byte of the addressed word. That byte is returned on the low lane while lanes 8 to 15 float. Bus writes are not applied to the array. They are forwarded as byte-wide commands to a downstream controller.

The array comes out of reset erased. A narrow store port lets that controller update words later. Program and erase sequencing, the command set and analog timing belong to other blocks.

Top module: `nvm_bus_front`

## Requirements
- R1: With `wide_sel` = 1 (16-bit mode), a read drives all three lane enables and `dq_out` carries the full 16-bit word at the addressed location.
- R2: With `wide_sel` = 0 (8-bit mode), `dq_in[15]` acts as the lowest address bit. 0 returns bits 7:0 of the addressed word and 1 returns bits 15:8, placed on `dq_out[7:0]`.
- R3: In 8-bit mode, `lane_mid_oe` (lanes 8-14) and `lane_top_oe` (lane 15) stay low, and `dq_out[15:8]` reads 0.
- R4: While `ce_n` is high, no lane enable rises and no command is issued, whatever the other inputs do.
- R5: A read is active only when `ce_n` = 0, `oe_n` = 0 and `we_n` = 1. The outputs reflect the bus as sampled on the second rising clock edge before they are observed. When no read is active, all enables and `dq_out` are 0.
- R6: When `oe_n` and `we_n` are both low, nothing is driven and no command is issued.
- R7: A command pulse is issued when `we_n` is seen rising in samples where `ce_n` = 0 and `oe_n` = 1. `cmd_valid` is high for exactly one cycle, one clock after the sample that shows `we_n` high. `cmd_data` is `dq_in[7:0]` from that sample, and bits 15:8 are ignored. `cmd_data` and `cmd_addr` are 0 whenever `cmd_valid` is 0.
- R8: `cmd_addr` is a 21-bit byte address. In 16-bit mode it is {`addr`, 0`}. In 8-bit mode it is {`addr`, `dq_in[15]`}.
- R9: After reset every array word reads 16'hFFFF, and all outputs are 0 while reset is held.
- R10: A `st_en` pulse writes `st_data` to word `st_idx`. Reads whose clock edge comes after the store return the new value. The array is indexed by the low `IDX_W` bits of `addr`, so higher addresses alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide_sel | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| addr | input | 20 | Word address |
| dq_in | input | 16 | Data bus as seen by the pins |
| dq_out | output | 16 | Data driven toward the pins |
| lane_lo_oe | output | 1 | Output enable, lanes 0-7 |
| lane_mid_oe | output | 1 | Output enable, lanes 8-14 |
| lane_top_oe | output | 1 | Output enable, lane 15 |
| st_en | input | 1 | Array store strobe |
| st_idx | input | 4 | Array word index for a store |
| st_data | input | 16 | Word to store |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_addr | output | 21 | Byte address of the command |
| cmd_data | output | 8 | Command byte |

## Verification
The assertions assume that the strobes reach the clock domain cleanly. They assume `we_n` never rises on two consecutive sampled cycles and that `wide_sel` only changes while the chip is deselected. The stimulus moves the strobes through bus-level tasks that hold each level for at least two clocks. Address and data are held steady around each write-enable edge, and the bus width is changed only between accesses, with `ce_n` high.

// File: rtl/nvm_bus_pkg.sv
// Shared widths and the sampled-bus record used across the bus front end.
// Assumes a 20-bit word address and a 16-bit data bus.
package nvm_bus_pkg;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CADDR_W = ADDR_W + 1;

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dq;
    } bus_smp_t;

    localparam bus_smp_t SMP_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                     wide: 1'b1, addr: '0, dq: '0};
endpackage

// File: rtl/nvm_bus_sampler.sv
// Registers the external bus once into the clock domain and keeps the
// previous write-enable level for edge detection.
// Assumes the strobes already meet setup to clk (synchronised upstream).
module nvm_bus_sampler
    import nvm_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wide_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output bus_smp_t          smp,
    output logic              we_prev
);
    // Capture the bus each cycle; reset to a deselected idle bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp     <= SMP_IDLE;
            we_prev <= 1'b1;
        end else begin
            smp     <= '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                         wide: wide_sel, addr: addr, dq: dq_in};
            we_prev <= smp.we_n;
        end
    end
endmodule

// File: rtl/nvm_cell_array.sv
// Small word array, erased to all ones at reset, with a store port and an
// asynchronous read by index.
// Assumes one store per cycle at most; WORDS is a power of two.
module nvm_cell_array
    import nvm_bus_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [DATA_W-1:0] st_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] cells [WORDS];

    // One register per word: erase on reset, load on a matching store.
    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= '1;
            else if (st_en && st_idx == IDX_W'(g))
                cells[g] <= st_data;
        end
    end

    // Combinational read of the selected word.
    always_comb rd_word = cells[rd_idx];

    assert_store_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && rd_idx == st_idx) |=> (rd_word == $past(st_data)));
endmodule

// File: rtl/nvm_lane_driver.sv
// Decides whether a read is active, selects the byte in 8-bit mode and
// drives the three lane-group output enables.
// Assumes a sampled bus record and the word already fetched from the array.
module nvm_lane_driver
    import nvm_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_smp_t          smp,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dq_out,
    output logic              lane_lo_oe,
    output logic              lane_mid_oe,
    output logic              lane_top_oe
);
    logic              rd_act;
    logic [BYTE_W-1:0] byte_pick;
    logic [DATA_W-1:0] dq_nxt;

    // Read needs chip and output enabled with write enable idle.
    always_comb rd_act = !smp.ce_n && !smp.oe_n && smp.we_n;

    // In 8-bit mode the top data pin selects the byte half.
    always_comb byte_pick = smp.dq[DATA_W-1] ? word[DATA_W-1:BYTE_W] : word[BYTE_W-1:0];

    // Form the next output word; undriven lanes read as zero.
    always_comb begin
        dq_nxt = '0;
        if (rd_act)
            dq_nxt = smp.wide ? word : {{(DATA_W-BYTE_W){1'b0}}, byte_pick};
    end

    // Register data and lane enables toward the pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out      <= '0;
            lane_lo_oe  <= 1'b0;
            lane_mid_oe <= 1'b0;
            lane_top_oe <= 1'b0;
        end else begin
            dq_out      <= dq_nxt;
            lane_lo_oe  <= rd_act;
            lane_mid_oe <= rd_act && smp.wide;
            lane_top_oe <= rd_act && smp.wide;
        end
    end

    assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp.ce_n |=> !lane_lo_oe && !lane_mid_oe && !lane_top_oe);
    assert_byte_upper_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp.wide |=> !lane_mid_oe && !lane_top_oe && dq_out[DATA_W-1:BYTE_W] == '0);
    assert_contention_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.oe_n && !smp.we_n) |=> !lane_lo_oe);
    assert_upper_needs_lower_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mid_oe |-> lane_lo_oe);
endmodule

// File: rtl/nvm_cmd_capture.sv
// Detects a write-enable rising edge with the chip selected and output
// enable idle, and emits one command pulse with a byte address and byte.
// Assumes address and data are stable in the sample that shows we_n high.
module nvm_cmd_capture
    import nvm_bus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  bus_smp_t           smp,
    input  logic               we_prev,
    output logic               cmd_valid,
    output logic [CADDR_W-1:0] cmd_addr,
    output logic [BYTE_W-1:0]  cmd_data
);
    logic wr_edge;
    logic lsb;

    // Rising write enable while selected and not reading.
    always_comb wr_edge = smp.we_n && !we_prev && !smp.ce_n && smp.oe_n;

    // Lowest byte-address bit: 0 in 16-bit mode, the top data pin otherwise.
    always_comb lsb = smp.wide ? 1'b0 : smp.dq[DATA_W-1];

    // Register the pulse and its payload; payload is zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= wr_edge;
            cmd_addr  <= wr_edge ? {smp.addr, lsb} : '0;
            cmd_data  <= wr_edge ? smp.dq[BYTE_W-1:0] : '0;
        end
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    assert_cmd_needs_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp.ce_n |=> !cmd_valid);
    assert_cmd_not_in_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp.oe_n |=> !cmd_valid);
endmodule

// File: rtl/nvm_bus_front.sv
// Top of the bus front end: sampler, array, read lane driver and command
// capture. Assumes wide_sel changes only while the chip is deselected.
module nvm_bus_front
    import nvm_bus_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic               wide_sel,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  dq_in,
    output logic [DATA_W-1:0]  dq_out,
    output logic               lane_lo_oe,
    output logic               lane_mid_oe,
    output logic               lane_top_oe,
    input  logic               st_en,
    input  logic [IDX_W-1:0]   st_idx,
    input  logic [DATA_W-1:0]  st_data,
    output logic               cmd_valid,
    output logic [CADDR_W-1:0] cmd_addr,
    output logic [BYTE_W-1:0]  cmd_data
);
    bus_smp_t          smp;
    logic              we_prev;
    logic [DATA_W-1:0] word;

    nvm_bus_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wide_sel(wide_sel), .addr(addr), .dq_in(dq_in),
        .smp(smp), .we_prev(we_prev)
    );

    nvm_cell_array #(.WORDS(WORDS)) u_arr (
        .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_idx(st_idx),
        .st_data(st_data), .rd_idx(smp.addr[IDX_W-1:0]), .rd_word(word)
    );

    nvm_lane_driver u_lane (
        .clk(clk), .rst_n(rst_n), .smp(smp), .word(word), .dq_out(dq_out),
        .lane_lo_oe(lane_lo_oe), .lane_mid_oe(lane_mid_oe), .lane_top_oe(lane_top_oe)
    );

    nvm_cmd_capture u_cmd (
        .clk(clk), .rst_n(rst_n), .smp(smp), .we_prev(we_prev),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    assert_read_only_when_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_lo_oe |-> $past(!smp.ce_n && !smp.oe_n && smp.we_n));
endmodule

// File: tb/nvm_bus_front_tb.sv
module nvm_bus_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide_sel = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        lane_lo_oe, lane_mid_oe, lane_top_oe;
    logic        st_en = 1'b0;
    logic [3:0]  st_idx = '0;
    logic [15:0] st_data = '0;
    logic        cmd_valid;
    logic [20:0] cmd_addr;
    logic [7:0]  cmd_data;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_req = "R9";

    always #10 clk = ~clk;

    nvm_bus_front dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wide_sel(wide_sel), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .lane_lo_oe(lane_lo_oe), .lane_mid_oe(lane_mid_oe), .lane_top_oe(lane_top_oe),
        .st_en(st_en), .st_idx(st_idx), .st_data(st_data),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    // Behavioural reference: previous bus sample, array contents, expectations.
    bit          m_ce, m_oe, m_we, m_wide, m_pwe;
    bit [19:0]   m_addr;
    bit [15:0]   m_dq;
    bit [15:0]   m_mem [16];
    bit [15:0]   e_dq;
    bit          e_lo, e_mid, e_top, e_cv;
    bit [20:0]   e_ca;
    bit [7:0]    e_cd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ce = 1; m_oe = 1; m_we = 1; m_pwe = 1; m_wide = 1; m_addr = 0; m_dq = 0;
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            e_dq = 0; e_lo = 0; e_mid = 0; e_top = 0; e_cv = 0; e_ca = 0; e_cd = 0;
        end else begin
            bit        rd;
            bit [15:0] w;
            rd    = !m_ce && !m_oe && m_we;
            w     = m_mem[m_addr % 16];
            e_lo  = rd;
            e_mid = rd && m_wide;
            e_top = rd && m_wide;
            e_dq  = !rd ? 16'h0 : (m_wide ? w : {8'h0, (m_dq[15] ? w[15:8] : w[7:0])});
            e_cv  = m_we && !m_pwe && !m_ce && m_oe;
            e_ca  = e_cv ? {m_addr, (m_wide ? 1'b0 : m_dq[15])} : 21'h0;
            e_cd  = e_cv ? m_dq[7:0] : 8'h0;
            if (st_en) m_mem[st_idx] = st_data;
            m_pwe = m_we;
            m_ce = ce_n; m_oe = oe_n; m_we = we_n; m_wide = wide_sel;
            m_addr = addr; m_dq = dq_in;
        end
    end

    // Compare every output on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if ({lane_lo_oe, lane_mid_oe, lane_top_oe} !== {e_lo, e_mid, e_top}) begin
                errors++;
                $display("FAIL %s lane enables actual=%b%b%b expected=%b%b%b", cur_req,
                         lane_lo_oe, lane_mid_oe, lane_top_oe, e_lo, e_mid, e_top);
            end
            checks++;
            if (dq_out !== e_dq) begin
                errors++;
                $display("FAIL %s dq_out actual=%h expected=%h", cur_req, dq_out, e_dq);
            end
            checks++;
            if ({cmd_valid, cmd_addr, cmd_data} !== {e_cv, e_ca, e_cd}) begin
                errors++;
                $display("FAIL %s cmd actual=%b/%h/%h expected=%b/%h/%h", cur_req,
                         cmd_valid, cmd_addr, cmd_data, e_cv, e_ca, e_cd);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input bit [19:0] a, input bit wide, input bit hi);
        @(negedge clk);
        wide_sel = wide; addr = a; dq_in = {hi, 15'h0};
        ce_n = 0; oe_n = 0; we_n = 1;
        idle(3);
        ce_n = 1; oe_n = 1;
        idle(2);
    endtask

    task automatic bus_write(input bit [19:0] a, input bit [15:0] d, input bit wide);
        @(negedge clk);
        wide_sel = wide; addr = a; dq_in = d;
        ce_n = 0; oe_n = 1; we_n = 0;
        idle(2);
        we_n = 1;
        idle(3);
        ce_n = 1;
        idle(2);
    endtask

    task automatic store(input bit [3:0] i, input bit [15:0] d);
        @(negedge clk);
        st_en = 1; st_idx = i; st_data = d;
        @(negedge clk);
        st_en = 0;
    endtask

    initial begin
        cur_req = "R9";
        idle(3);
        rst_n = 1;
        idle(2);
        bus_read(20'h00003, 1, 0);          // erased word, 16-bit
        bus_read(20'h0000A, 0, 1);          // erased byte
        cur_req = "R10";
        store(4'h3, 16'hA55A);
        store(4'h7, 16'h1234);
        store(4'hC, 16'hBEEF);
        bus_read(20'h00007, 1, 0);
        bus_read(20'hF0007, 1, 0);          // aliases onto word 7
        cur_req = "R1";
        bus_read(20'h00003, 1, 0);
        bus_read(20'h0000C, 1, 1);          // top pin is data in 16-bit mode
        cur_req = "R2";
        bus_read(20'h00007, 0, 0);
        bus_read(20'h00007, 0, 1);
        cur_req = "R3";
        bus_read(20'h0000C, 0, 1);
        bus_read(20'h00003, 0, 0);
        cur_req = "R4";
        @(negedge clk);
        ce_n = 1; oe_n = 0; we_n = 1; addr = 20'h3;
        idle(3);
        we_n = 0; oe_n = 1; idle(2); we_n = 1; idle(3);
        oe_n = 1;
        cur_req = "R5";
        @(negedge clk);
        ce_n = 0; oe_n = 1; we_n = 1; addr = 20'h7; idle(3);   // selected, no read
        oe_n = 0; idle(1); oe_n = 1; idle(1); oe_n = 0; idle(3);
        ce_n = 1; oe_n = 1; idle(2);
        cur_req = "R6";
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 0; addr = 20'hC; dq_in = 16'h00AA; idle(3);
        we_n = 1; idle(3);                   // rise with oe low: no command
        ce_n = 1; oe_n = 1; idle(2);
        cur_req = "R7";
        bus_write(20'h00555, 16'hFFAA, 1);
        bus_write(20'h002AA, 16'h3C55, 1);
        cur_req = "R8";
        bus_write(20'h00AAA, 16'h80F0, 0);
        bus_write(20'h00555, 16'h0090, 0);
        bus_write(20'h12345, 16'h8001, 1);
        cur_req = "R9";
        @(negedge clk); rst_n = 0; idle(3); rst_n = 1; idle(2);
        bus_read(20'h00007, 1, 0);           // erased again after reset
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule